// File: doc/BRIEF.md
# AUX Reply Status Classifier

This block sits behind an auxiliary-channel line decoder. When a request has gone out on the channel, the decoder raises a done strobe. Along with it, the decoder presents a set of receiver status flags and the number of bytes it placed in the reply buffer. The classifier reduces all of this to one operation result, using a fixed order of precedence. It reads the reply code from the high nibble of buffer byte 0, reports how many data bytes follow it, and streams those bytes out only when the reply is an acknowledge.

A transaction starts with a `start` pulse. This clears the previous outcome and arms a polling timer. If the done strobe does not come within the programmed number of cycles, the block reports a timeout of its own. Once classified, the result stays on the outputs until the next `start`. A one-cycle `result_valid` pulse marks the moment the result is final. The reply buffer is read through an address/data port. The read data must be returned combinationally in the same cycle.

Top module: `aux_reply_classifier`

## Requirements
- R1: A hot-plug disconnect flag at the done strobe gives result 1 (HPD), whatever the other flags hold.
- R2: Without a disconnect, either the receive-timeout flag or the timeout-state flag gives result 2 (TIMEOUT), even if framing flags are also set.
- R3: Without disconnect or timeout flags, any of invalid-stop, no-detect, invalid-high or invalid-low gives result 3 (INVALID).
- R4: With no error flags, a reply byte count of zero gives result 3 (INVALID). For R1 to R4, `data_count` and `reply_code` stay 0 and no byte is streamed.
- R5: The minimum-count-violation flag has no effect on any output.
- R6: With no error and a count n of at least 1, `reply_code` equals bits [7:4] of buffer byte 0 and `data_count` equals n-1.
- R7: When `reply_code` is 0 (acknowledge), buffer bytes 1 to n-1 are streamed in address order on `out_data`, with `out_valid` high for exactly n-1 cycles, and the result is 0 (OK). With a non-zero reply code, nothing is streamed and the result is 0 (OK).
- R8: On an acknowledge with n-1 greater than `buf_size`, the result is 4 (OVERFLOW), `data_count` is n-1 and no byte is streamed. n-1 equal to `buf_size` streams normally.
- R9: If no done strobe is seen at the first `poll_limit` clock edges after the edge that takes `start`, the result is 2 (TIMEOUT). `result_valid` rises `poll_limit` edges after the start edge. A done strobe at edge `poll_limit` is still accepted.
- R10: `result_valid` is a single-cycle pulse. `result`, `reply_code` and `data_count` then hold until the next `start`, which clears them to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new transaction; clears outputs, arms timer |
| poll_limit | input | POLL_W | Cycles to wait for the done strobe |
| done | input | 1 | Decoder finished receiving the reply |
| st_hpd_discon | input | 1 | Sink disconnected |
| st_rx_timeout | input | 1 | Receiver timed out |
| st_rx_timeout_state | input | 1 | Receiver is in timeout state |
| st_inv_stop | input | 1 | Invalid stop pattern |
| st_no_detect | input | 1 | No reply detected |
| st_inv_high | input | 1 | Invalid high symbol |
| st_inv_low | input | 1 | Invalid low symbol |
| st_min_count_viol | input | 1 | Debug-only minimum-count flag (ignored) |
| reply_count | input | CNT_W | Bytes in the reply buffer, header included |
| buf_size | input | CNT_W | Caller's data buffer capacity in bytes |
| rd_addr | output | CNT_W | Reply buffer read address |
| rd_data | input | 8 | Reply buffer byte at `rd_addr` (same cycle) |
| result | output | 3 | 0 OK, 1 HPD, 2 TIMEOUT, 3 INVALID, 4 OVERFLOW |
| result_valid | output | 1 | One-cycle pulse when result is final |
| reply_code | output | 4 | High nibble of buffer byte 0 |
| data_count | output | CNT_W | Reply bytes minus header |
| out_valid | output | 1 | Streamed data byte valid |
| out_data | output | 8 | Streamed data byte |

## Verification
The flag inputs are driven in overlapping combinations: all flags set, timeout together with framing errors, and each framing flag on its own. These separate a correct precedence order from one that only works when a single flag is raised. Clean replies are run with acknowledge and non-acknowledge codes, a header-only reply, a zero count, and data lengths just at and just above the caller's buffer size. These show whether streaming is gated by the reply code and where the overflow bound sits. The polling limit is tried both with no done strobe and with the done strobe on the last allowed edge, which fixes the exact timeout latency.

// File: rtl/aux_cls_pkg.sv
package aux_cls_pkg;

   typedef enum logic [2:0] {
      RES_OK       = 3'd0,
      RES_HPD      = 3'd1,
      RES_TIMEOUT  = 3'd2,
      RES_INVALID  = 3'd3,
      RES_OVERFLOW = 3'd4
   } aux_res_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_HDR,
      ST_STREAM,
      ST_REPORT
   } aux_st_e;

   localparam int FRAMING_N = 4;

endpackage

// File: rtl/aux_poll_timer.sv
module aux_poll_timer #(
   parameter int POLL_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              run,
   input  logic [POLL_W-1:0] limit,
   output logic              expired
);
   localparam int EXT_W = POLL_W + 1;

   logic [POLL_W-1:0] elapsed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      elapsed <= '0;
      else if (clear)  elapsed <= '0;
      else if (run)    elapsed <= elapsed + POLL_W'(1);
   end

   assign expired = ({1'b0, elapsed} + EXT_W'(1)) >= {1'b0, limit};
endmodule

// File: rtl/aux_status_prio.sv
module aux_status_prio
   import aux_cls_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic                 hpd,
   input  logic                 rx_to,
   input  logic                 rx_to_state,
   input  logic [FRAMING_N-1:0] framing,
   input  logic [CNT_W-1:0]     count,
   output aux_res_e             verdict,
   output logic                 clean
);
   logic [FRAMING_N:0] framing_acc;

   assign framing_acc[0] = 1'b0;
   for (genvar gi = 0; gi < FRAMING_N; gi++) begin : g_or
      assign framing_acc[gi+1] = framing_acc[gi] | framing[gi];
   end

   always_comb begin
      clean   = 1'b0;
      verdict = RES_OK;
      if (hpd)                        verdict = RES_HPD;
      else if (rx_to || rx_to_state)  verdict = RES_TIMEOUT;
      else if (framing_acc[FRAMING_N]) verdict = RES_INVALID;
      else if (count == '0)           verdict = RES_INVALID;
      else                            clean = 1'b1;
   end
endmodule

// File: rtl/aux_reply_classifier.sv
module aux_reply_classifier
   import aux_cls_pkg::*;
#(
   parameter int CNT_W  = 5,
   parameter int POLL_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [POLL_W-1:0] poll_limit,
   input  logic              done,
   input  logic              st_hpd_discon,
   input  logic              st_rx_timeout,
   input  logic              st_rx_timeout_state,
   input  logic              st_inv_stop,
   input  logic              st_no_detect,
   input  logic              st_inv_high,
   input  logic              st_inv_low,
   input  logic              st_min_count_viol,
   input  logic [CNT_W-1:0]  reply_count,
   input  logic [CNT_W-1:0]  buf_size,
   output logic [CNT_W-1:0]  rd_addr,
   input  logic [7:0]        rd_data,
   output logic [2:0]        result,
   output logic              result_valid,
   output logic [3:0]        reply_code,
   output logic [CNT_W-1:0]  data_count,
   output logic              out_valid,
   output logic [7:0]        out_data
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("CNT_W out of range");
   end
   if (POLL_W < 2) begin : g_bad_poll
      $error("POLL_W too small");
   end

   aux_st_e          state;
   aux_res_e         verdict;
   logic             clean;
   logic             expired;
   logic [CNT_W-1:0] last_idx;
   logic             unused_dbg;

   assign unused_dbg = st_min_count_viol;

   aux_poll_timer #(.POLL_W(POLL_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (start),
      .run     (state == ST_WAIT),
      .limit   (poll_limit),
      .expired (expired)
   );

   aux_status_prio #(.CNT_W(CNT_W)) u_prio (
      .hpd         (st_hpd_discon),
      .rx_to       (st_rx_timeout),
      .rx_to_state (st_rx_timeout_state),
      .framing     ({st_inv_stop, st_no_detect, st_inv_high, st_inv_low}),
      .count       (reply_count),
      .verdict     (verdict),
      .clean       (clean)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         result     <= RES_OK;
         reply_code <= '0;
         data_count <= '0;
         last_idx   <= '0;
         rd_addr    <= '0;
         out_valid  <= 1'b0;
         out_data   <= '0;
      end else if (start) begin
         state      <= ST_WAIT;
         result     <= RES_OK;
         reply_code <= '0;
         data_count <= '0;
         rd_addr    <= '0;
         out_valid  <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         unique case (state)
            ST_WAIT: begin
               if (done) begin
                  if (!clean) begin
                     result <= verdict;
                     state  <= ST_REPORT;
                  end else begin
                     last_idx   <= reply_count - ONE;
                     data_count <= reply_count - ONE;
                     rd_addr    <= '0;
                     state      <= ST_HDR;
                  end
               end else if (expired) begin
                  result <= RES_TIMEOUT;
                  state  <= ST_REPORT;
               end
            end
            ST_HDR: begin
               reply_code <= rd_data[7:4];
               if (rd_data[7:4] != 4'd0 || last_idx == '0) begin
                  result <= RES_OK;
                  state  <= ST_REPORT;
               end else if (last_idx > buf_size) begin
                  result <= RES_OVERFLOW;
                  state  <= ST_REPORT;
               end else begin
                  rd_addr <= ONE;
                  state   <= ST_STREAM;
               end
            end
            ST_STREAM: begin
               out_valid <= 1'b1;
               out_data  <= rd_data;
               if (rd_addr == last_idx) begin
                  result <= RES_OK;
                  state  <= ST_REPORT;
               end else begin
                  rd_addr <= rd_addr + ONE;
               end
            end
            ST_REPORT: state <= ST_IDLE;
            default:   state <= ST_IDLE;
         endcase
      end
   end

   assign result_valid = (state == ST_REPORT);
endmodule

// File: rtl/aux_reply_classifier_chk.sv
module aux_reply_classifier_chk #(
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             waiting,
   input logic             done,
   input logic             hpd,
   input logic             to_any,
   input logic             framing_any,
   input logic [CNT_W-1:0] reply_count,
   input logic [2:0]       result,
   input logic             result_valid,
   input logic [3:0]       reply_code,
   input logic             out_valid
);
   assert_hpd_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
      waiting && done && !start && hpd |=> result_valid && result == 3'd1);

   assert_timeout_rank_R2: assert property (@(posedge clk) disable iff (!rst_n)
      waiting && done && !start && !hpd && to_any |=> result_valid && result == 3'd2);

   assert_framing_invalid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      waiting && done && !start && !hpd && !to_any && framing_any
      |=> result_valid && result == 3'd3);

   assert_zero_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
      waiting && done && !start && !hpd && !to_any && !framing_any && reply_count == '0
      |=> result_valid && result == 3'd3);

   assert_stream_on_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> reply_code == 4'd0);

   assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid);

   assert_result_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid && !start |=> $stable(result) && $stable(reply_code));
endmodule

bind aux_reply_classifier aux_reply_classifier_chk #(.CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .waiting      (state == aux_cls_pkg::ST_WAIT),
   .done         (done),
   .hpd          (st_hpd_discon),
   .to_any       (st_rx_timeout | st_rx_timeout_state),
   .framing_any  (st_inv_stop | st_no_detect | st_inv_high | st_inv_low),
   .reply_count  (reply_count),
   .result       (result),
   .result_valid (result_valid),
   .reply_code   (reply_code),
   .out_valid    (out_valid)
);

// File: tb/aux_reply_classifier_bench.sv
module aux_reply_classifier_bench;
   localparam int CNT_W  = 5;
   localparam int POLL_W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [POLL_W-1:0] poll_limit = 16'd20;
   logic done = 1'b0;
   logic [7:0] fl = 8'h00;
   logic [CNT_W-1:0] reply_count = '0;
   logic [CNT_W-1:0] buf_size = '0;
   logic [CNT_W-1:0] rd_addr;
   logic [7:0] rd_data;
   logic [2:0] result;
   logic result_valid;
   logic [3:0] reply_code;
   logic [CNT_W-1:0] data_count;
   logic out_valid;
   logic [7:0] out_data;
   logic [7:0] mem [0:31];

   int n_checks = 0;
   int n_fail = 0;

   always #10 clk = ~clk;
   assign rd_data = mem[rd_addr];

   aux_reply_classifier #(.CNT_W(CNT_W), .POLL_W(POLL_W)) u_aux_reply_classifier (
      .clk(clk), .rst_n(rst_n), .start(start), .poll_limit(poll_limit), .done(done),
      .st_hpd_discon(fl[7]), .st_rx_timeout(fl[6]), .st_rx_timeout_state(fl[5]),
      .st_inv_stop(fl[4]), .st_no_detect(fl[3]), .st_inv_high(fl[2]),
      .st_inv_low(fl[1]), .st_min_count_viol(fl[0]),
      .reply_count(reply_count), .buf_size(buf_size), .rd_addr(rd_addr), .rd_data(rd_data),
      .result(result), .result_valid(result_valid), .reply_code(reply_code),
      .data_count(data_count), .out_valid(out_valid), .out_data(out_data));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // flags: [7]hpd [6]timeout [5]timeout-state [4]stop [3]no-det [2]inv-high [1]inv-low [0]min-count
   task automatic run(input logic [7:0] flags, input int n, input int bsz, input int dly,
                      input int lim, input string req);
      int exp_res, exp_code, exp_cnt, cyc, got_res, got_code, got_cnt;
      logic [7:0] exp_q[$];
      logic [7:0] got_q[$];
      exp_code = 0; exp_cnt = 0;
      if (dly < 0)                  exp_res = 2;
      else if (flags[7])            exp_res = 1;
      else if (flags[6] | flags[5]) exp_res = 2;
      else if (|flags[4:1])         exp_res = 3;
      else if (n == 0)              exp_res = 3;
      else begin
         exp_code = int'(mem[0] >> 4);
         exp_cnt  = n - 1;
         if (exp_code == 0 && n - 1 > bsz) exp_res = 4;
         else begin
            exp_res = 0;
            if (exp_code == 0) for (int i = 1; i < n; i++) exp_q.push_back(mem[i]);
         end
      end
      @(negedge clk);
      poll_limit = POLL_W'(lim); reply_count = CNT_W'(n); buf_size = CNT_W'(bsz);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0; cyc = 0;
      if (dly >= 0) begin
         repeat (dly) begin @(negedge clk); cyc++; end
         done = 1'b1; fl = flags;
      end
      for (int guard = 0; guard < 300; guard++) begin
         @(negedge clk);
         cyc++;
         done = 1'b0; fl = 8'h00;
         if (out_valid) got_q.push_back(out_data);
         if (result_valid) break;
      end
      got_res = int'(result); got_code = int'(reply_code); got_cnt = int'(data_count);
      chk(result_valid == 1'b1, {req, " result_valid seen"}, int'(result_valid), 1);
      chk(got_res == exp_res, {req, " result"}, got_res, exp_res);
      chk(got_code == exp_code, {req, " reply_code"}, got_code, exp_code);
      chk(got_cnt == exp_cnt, {req, " data_count"}, got_cnt, exp_cnt);
      chk(got_q.size() == exp_q.size(), {req, " streamed byte count"}, got_q.size(), exp_q.size());
      for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
         chk(got_q[i] == exp_q[i], {req, " streamed byte"}, int'(got_q[i]), int'(exp_q[i]));
      if (dly < 0) chk(cyc == lim, {req, " timeout latency R9"}, cyc, lim);
      @(negedge clk);
      chk(result_valid == 1'b0, {req, " pulse width R10"}, int'(result_valid), 0);
      chk(int'(result) == exp_res && int'(reply_code) == exp_code,
          {req, " held R10"}, int'(result), exp_res);
   endtask

   initial begin
      #(20 * 150000);
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 32; i++) mem[i] = 8'(8'h30 + i * 7);
      repeat (3) @(negedge clk);
      chk(result_valid == 1'b0 && out_valid == 1'b0, "reset R10 valids", int'(result_valid), 0);
      chk(result == 3'd0 && data_count == '0, "reset R10 result", int'(result), 0);
      rst_n = 1'b1;

      mem[0] = 8'h0A;
      run(8'h00, 5, 8, 3, 20, "R6 R7 ack stream");
      run(8'hFE, 5, 8, 2, 20, "R1 all flags");
      run(8'h80, 5, 8, 0, 20, "R1 hpd only");
      run(8'h5E, 5, 8, 1, 20, "R2 timeout with framing");
      run(8'h20, 5, 8, 1, 20, "R2 timeout-state");
      run(8'h10, 5, 8, 1, 20, "R3 invalid stop");
      run(8'h08, 5, 8, 1, 20, "R3 no detect");
      run(8'h04, 5, 8, 1, 20, "R3 invalid high");
      run(8'h02, 5, 8, 1, 20, "R3 invalid low");
      run(8'h00, 0, 8, 1, 20, "R4 zero count");
      run(8'h01, 0, 8, 1, 20, "R4 R5 zero count with debug flag");
      run(8'h01, 4, 8, 2, 20, "R5 debug flag on ack");
      run(8'h00, 1, 0, 1, 20, "R6 header only");
      mem[0] = 8'h2F;
      run(8'h00, 6, 8, 1, 20, "R7 non-ack code");
      mem[0] = 8'h05;
      run(8'h00, 7, 5, 1, 20, "R8 overflow");
      run(8'h00, 6, 5, 1, 20, "R8 at buffer size");
      run(8'h00, 20, 31, 4, 20, "R7 long stream");
      run(8'h00, 3, 8, -1, 5, "R9 no done");
      run(8'h00, 3, 8, 4, 5, "R9 done on last edge");
      run(8'h00, 3, 8, -1, 1, "R9 limit one");

      run(8'h80, 3, 8, 1, 20, "R10 setup");
      repeat (3) @(negedge clk);
      chk(result == 3'd1, "R10 held after idle", int'(result), 1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(result == 3'd0 && reply_code == 4'd0 && data_count == '0,
          "R10 start clears", int'(result), 0);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule